// File: doc/BRIEF.md
# GPIO Port with Change Interrupts

This block is a memory-mapped general-purpose I/O port of up to 32 pins. It holds a per-pin direction setting, a per-pin change-interrupt enable and an output value, and it records input transitions in a change status register. Software reaches these through a simple single-cycle register bus. Each pin is an input after reset. A pin set to output drives its bit of the value register onto `pin_out` and raises its bit of `pin_oe`. The pad buffers themselves sit outside the block.

Every pad input first passes through a two-stage synchronizer. A transition in either direction on a pin that is an input and has its enable set latches that pin's status bit. The `irq` output stays high for as long as any status bit is set. Software handles an interrupt in a loop. It reads the status, reads the value register to get the current pin levels, writes the status bits it saw back as ones to clear them, and repeats until a status read returns zero. A new change that lands in the same cycle as the clear of its bit is kept. A read-only capability word shows that the port is present.

Top module: `gpio_chg_port`

## Requirements
- R1: After reset, the direction, enable, value and status registers all read zero, `pin_oe` is zero and `irq` is low.
- R2: Writing the direction register (offset 0x08) sets `pin_oe` to the written bits on the next edge, where 1 means output. Writing the value register (offset 0x10) sets `pin_out` to the written bits on the next edge.
- R3: A read of the value register returns, bit by bit, the written value for output pins and the synchronized pad level for input pins.
- R4: A rising or a falling transition on a pin that is an input with its enable bit set (offset 0x0C) sets that pin's status bit (offset 0x14) on the third rising edge after the pad changes.
- R5: A transition on a pin that is configured as an output, or whose enable bit is clear, never sets its status bit.
- R6: Writing the status register clears each bit written as 1 and leaves each bit written as 0 unchanged. Status bits are never cleared in any other way.
- R7: If a change event and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R8: `irq` is high exactly when the status register is nonzero.
- R9: The capability word at offset 0x04 reads 0x00000020, with bit 5 set to flag the port's presence. Writes to it have no effect.
- R10: Read data appears on `bus_rdata` one cycle after the `bus_rd` strobe and holds until the next read. Unmapped offsets read zero.
- R11: Writing zero to the enable register stops all further change events but leaves the status bits already set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pin_in | input | NUM_PINS | Pad input levels, asynchronous |
| pin_out | output | NUM_PINS | Pad output values |
| pin_oe | output | NUM_PINS | Pad output enables |
| irq | output | 1 | Level interrupt, high while any change is pending |

## Verification
The assertions assume that the bus strobes, address and write data are settled at each rising edge. They also assume that a rise in a status bit can be traced to the direction and enable values held one cycle earlier, which depends on the synchronizer being the only path from the pads. The bench changes pads and bus inputs only on falling edges and holds each strobe for exactly one cycle. It waits out the synchronizer delay before it reads back anything that depends on a pad change. The one exception is the same-cycle collision case, where it places the clearing write deliberately on the edge that latches the event.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;

  // Register byte offsets
  localparam logic [15:0] OFF_CAP  = 16'h0004;
  localparam logic [15:0] OFF_DIR  = 16'h0008;
  localparam logic [15:0] OFF_IEN  = 16'h000C;
  localparam logic [15:0] OFF_VAL  = 16'h0010;
  localparam logic [15:0] OFF_STAT = 16'h0014;

  localparam int unsigned BUS_W   = 32;
  localparam int unsigned CAP_BIT = 5;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CAP,
    SEL_DIR,
    SEL_IEN,
    SEL_VAL,
    SEL_STAT
  } reg_sel_e;

  function automatic reg_sel_e decode_off(input logic [15:0] off);
    case (off)
      OFF_CAP:  return SEL_CAP;
      OFF_DIR:  return SEL_DIR;
      OFF_IEN:  return SEL_IEN;
      OFF_VAL:  return SEL_VAL;
      OFF_STAT: return SEL_STAT;
      default:  return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] level,
  output logic [NUM_PINS-1:0] toggled
);
  localparam int unsigned LAST = STAGES - 1;

  logic [NUM_PINS-1:0] stage_q [STAGES];
  logic [NUM_PINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
      prev_q <= '0;
    end else begin
      stage_q[0] <= pad_in;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      prev_q <= stage_q[LAST];
    end
  end

  assign level   = stage_q[LAST];
  assign toggled = stage_q[LAST] ^ prev_q;

endmodule

// File: rtl/gpio_ctl_regs.sv
module gpio_ctl_regs #(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_dir,
  input  logic                wr_ien,
  input  logic                wr_val,
  input  logic [NUM_PINS-1:0] wdata,
  output logic [NUM_PINS-1:0] dir_q,
  output logic [NUM_PINS-1:0] ien_q,
  output logic [NUM_PINS-1:0] out_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      ien_q <= '0;
      out_q <= '0;
    end else begin
      if (wr_dir) dir_q <= wdata;
      if (wr_ien) ien_q <= wdata;
      if (wr_val) out_q <= wdata;
    end
  end
endmodule

// File: rtl/gpio_chg_status.sv
module gpio_chg_status #(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] toggled,
  input  logic [NUM_PINS-1:0] dir,
  input  logic [NUM_PINS-1:0] ien,
  input  logic                wr_stat,
  input  logic [NUM_PINS-1:0] wdata,
  output logic [NUM_PINS-1:0] stat_q,
  output logic                irq
);
  logic [NUM_PINS-1:0] stat_d;

  // Per pin: a new event outranks a clear in the same cycle
  genvar g;
  generate
    for (g = 0; g < NUM_PINS; g++) begin : g_pin
      logic hit;
      logic wipe;
      assign hit  = toggled[g] & ~dir[g] & ien[g];
      assign wipe = wr_stat & wdata[g];
      assign stat_d[g] = hit | (stat_q[g] & ~wipe);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign irq = |stat_q;

endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port
  import gpio_chg_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq
);
  localparam logic [BUS_W-1:0] CAP_WORD = BUS_W'(1) << CAP_BIT;

  reg_sel_e            sel;
  logic [NUM_PINS-1:0] wd;
  logic [NUM_PINS-1:0] dir_q, ien_q, out_q, stat_q;
  logic [NUM_PINS-1:0] pad_lvl, pad_tog, val_rd;
  logic [BUS_W-1:0]    rd_mux;
  logic [BUS_W-1:0]    rdata_q;

  assign sel = decode_off(16'(bus_addr));
  assign wd  = bus_wdata[NUM_PINS-1:0];

  gpio_in_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pad_in  (pin_in),
    .level   (pad_lvl),
    .toggled (pad_tog)
  );

  gpio_ctl_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_dir (bus_wr && sel == SEL_DIR),
    .wr_ien (bus_wr && sel == SEL_IEN),
    .wr_val (bus_wr && sel == SEL_VAL),
    .wdata  (wd),
    .dir_q  (dir_q),
    .ien_q  (ien_q),
    .out_q  (out_q)
  );

  gpio_chg_status #(.NUM_PINS(NUM_PINS)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .toggled (pad_tog),
    .dir     (dir_q),
    .ien     (ien_q),
    .wr_stat (bus_wr && sel == SEL_STAT),
    .wdata   (wd),
    .stat_q  (stat_q),
    .irq     (irq)
  );

  // Outputs show the written value, inputs show the synchronized pad
  assign val_rd = (dir_q & out_q) | (~dir_q & pad_lvl);

  always_comb begin
    case (sel)
      SEL_CAP:  rd_mux = CAP_WORD;
      SEL_DIR:  rd_mux = BUS_W'(dir_q);
      SEL_IEN:  rd_mux = BUS_W'(ien_q);
      SEL_VAL:  rd_mux = BUS_W'(val_rd);
      SEL_STAT: rd_mux = BUS_W'(stat_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
  assign pin_out   = out_q;
  assign pin_oe    = dir_q;

endmodule

// File: rtl/gpio_chg_chk.sv
module gpio_chg_chk
  import gpio_chg_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned ADDR_W   = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [31:0]         bus_wdata,
  input logic [31:0]         bus_rdata,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [NUM_PINS-1:0] stat_q,
  input logic [NUM_PINS-1:0] ien_q
);
  logic [15:0] a16;
  logic        wr_stat, rd_cap, rd_hole;
  logic [NUM_PINS-1:0] wd;

  assign a16     = 16'(bus_addr);
  assign wd      = bus_wdata[NUM_PINS-1:0];
  assign wr_stat = bus_wr && a16 == OFF_STAT;
  assign rd_cap  = bus_rd && a16 == OFF_CAP;
  assign rd_hole = bus_rd && a16 != OFF_CAP && a16 != OFF_DIR && a16 != OFF_IEN
                   && a16 != OFF_VAL && a16 != OFF_STAT;

  // R2
  dir_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && a16 == OFF_DIR) |=> pin_oe == $past(wd));

  // R2
  out_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && a16 == OFF_VAL) |=> pin_out == $past(wd));

  // R5
  no_event_on_masked_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & ~$past(stat_q) & ($past(pin_oe) | ~$past(ien_q))) == '0);

  // R6
  clear_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stat_q) & ~stat_q & ~({NUM_PINS{$past(wr_stat)}} & $past(wd))) == '0);

  // R9
  cap_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cap |=> bus_rdata == 32'h0000_0020);

  // R10
  hole_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hole |=> bus_rdata == 32'h0);

endmodule

bind gpio_chg_port gpio_chg_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .stat_q    (stat_q),
  .ien_q     (ien_q)
);

// File: tb/tb_gpio_chg_port.sv
`timescale 1ns/1ps
module tb_gpio_chg_port;
  localparam int unsigned NP = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pin_in = '0, pin_out, pin_oe;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  gpio_chg_port dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Called at a falling edge, returns at the next falling edge
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] exp_val(input logic [31:0] dir, input logic [31:0] outv,
                                          input logic [31:0] pads);
    return (dir & outv) | (~dir & pads);
  endfunction

  function automatic logic [31:0] exp_events(input logic [31:0] tog, input logic [31:0] dir,
                                             input logic [31:0] ien);
    return tog & ~dir & ien;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, dir_m, ien_m, out_m, tog, ev, msk;
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pin_oe", pin_oe, '0);
    check("R1 irq", 32'(irq), 0);
    bus_read(8'h08, rd); check("R1 dir", rd, 0);
    bus_read(8'h0C, rd); check("R1 ien", rd, 0);
    bus_read(8'h10, rd); check("R1 val", rd, 0);
    bus_read(8'h14, rd); check("R1 stat", rd, 0);
    // R9 capability, write ignored
    bus_write(8'h04, 32'hFFFF_FFFF);
    bus_read(8'h04, rd); check("R9 cap", rd, 32'h20);
    // R10 unmapped and hold
    bus_read(8'h18, rd); check("R10 hole", rd, 0);
    bus_read(8'h05, rd); check("R10 misaligned", rd, 0);
    repeat (2) @(negedge clk);
    check("R10 hold", bus_rdata, 0);

    // R4 directed: pin 5 rise then fall
    bus_write(8'h0C, 32'h20);
    pin_in[5] = 1'b1; repeat (2) @(negedge clk);
    check("R4 not yet", 32'(irq), 0);
    @(negedge clk);
    check("R4 rise irq", 32'(irq), 1);
    bus_read(8'h14, rd); check("R4 rise", rd, 32'h20);
    bus_write(8'h14, 32'h20);
    check("R8 irq clear", 32'(irq), 0);
    pin_in[5] = 1'b0; repeat (4) @(negedge clk);
    bus_read(8'h14, rd); check("R4 fall", rd, 32'h20);
    bus_write(8'h14, 32'h20);

    // R7 + R6: bit0 pending, bit1 pending; clear both as bit0 gets a new event
    bus_write(8'h0C, 32'h3);
    pin_in[1:0] = 2'b11; repeat (4) @(negedge clk);
    bus_read(8'h14, rd); check("R4 two pins", rd, 32'h3);
    pin_in[0] = 1'b0;
    @(negedge clk); @(negedge clk);
    bus_write(8'h14, 32'h3);
    bus_read(8'h14, rd); check("R7 collision", rd, 32'h1);
    bus_write(8'h14, 32'h0);
    bus_read(8'h14, rd); check("R6 zero write", rd, 32'h1);
    bus_write(8'h14, 32'h1);
    bus_read(8'h14, rd); check("R6 clear", rd, 32'h0);

    // R11: set a pending bit, disable all, toggle again
    pin_in[1] = 1'b0; repeat (4) @(negedge clk);
    bus_write(8'h0C, 32'h0);
    pin_in[0] = 1'b1; pin_in[7] = 1'b1; repeat (4) @(negedge clk);
    bus_read(8'h14, rd); check("R11 kept only old", rd, 32'h2);
    check("R8 irq pending", 32'(irq), 1);
    bus_write(8'h14, 32'hFFFF_FFFF);

    // R5 output pin ignored even with enable
    bus_write(8'h08, 32'h100); bus_write(8'h0C, 32'h100);
    pin_in[8] = 1'b1; repeat (4) @(negedge clk);
    bus_read(8'h14, rd); check("R5 output pin", rd, 0);
    pin_in = '0; bus_write(8'h08, 32'h0); repeat (4) @(negedge clk);
    bus_write(8'h14, 32'hFFFF_FFFF);

    // Random phase
    for (int it = 0; it < 24; it++) begin
      dir_m = $urandom; ien_m = $urandom; out_m = $urandom;
      bus_write(8'h08, dir_m);
      bus_write(8'h0C, ien_m);
      bus_write(8'h10, out_m);
      check("R2 oe", pin_oe, dir_m);
      check("R2 out", pin_out, out_m);
      bus_write(8'h14, 32'hFFFF_FFFF);
      tog = $urandom;
      pin_in = pin_in ^ tog;
      repeat (4) @(negedge clk);
      ev = exp_events(tog, dir_m, ien_m);
      bus_read(8'h14, rd); check("R4 R5 random stat", rd, ev);
      check("R8 random irq", 32'(irq), 32'(ev != 0));
      bus_read(8'h10, rd); check("R3 value", rd, exp_val(dir_m, out_m, pin_in));
      msk = $urandom;
      bus_write(8'h14, msk);
      bus_read(8'h14, rd); check("R6 random clear", rd, ev & ~msk);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule